// File: doc/BRIEF.md
# Message-Signalled Interrupt Write Composer

This block converts interrupt sources into message-signalled interrupt writes. Each source has a pending bit, set by a one-cycle pulse on its set input, and an enable level. When the domain enable is on, the block picks the lowest-numbered source that is both pending and enabled and clears that source's pending bit. It then presents one write request: a 64-bit byte address and a 32-bit data word that carries the source's interrupt identity.

The address comes from a per-source target word and from one of two address configuration pairs. The target word holds the destination hart index, the guest index and the identity. The machine-level pair serves a machine-level instance and the supervisor-level pair serves a supervisor-level instance. The hart index is split into a group part and a member part. Each part is placed into the page number at a configurable shift and width. A lock flag in the machine-level high word freezes all four configuration words.

Software can also write a generate register to send a single message directly to a chosen hart. The request leaves the block on a valid/ready handshake and stays stable until it is accepted.

Top module: `msi_msg_composer`

## Requirements
- R1: After reset, msg_valid_o is 0 and src_pend_o is all zeros.
- R2: Register writes use reg_kind_i. The encodings are 0 = machine low word, 1 = machine high word, 2 = supervisor low word, 3 = supervisor high word, 4 = generate, 5 = target word of source reg_idx_i. Codes 6 and 7 are ignored. In a high word, bits 11:0 are the upper 12 bits of the base page number, bits 15:12 are the member width LW, bits 18:16 are the group width GW, bits 22:20 are the member shift LS and bits 28:24 are the group shift GS.
- R3: The message address is computed as follows. G = hart >> LW and M = hart & (2^LW-1). PPN = {base_hi, low word} | ((G & (2^GW-1)) << (GS+12)) | (M << LS) | (guest & (2^LS-1)). The address is PPN << 12.
- R4: In a target word, bits 31:18 are the hart index, bits 17:12 are the guest index and bits 10:0 are the identity. The message data is the identity, zero-extended to 32 bits.
- R5: With mlevel_i = 1 the machine pair is used and the guest index is forced to 0. With mlevel_i = 0 the supervisor pair and the target's guest index are used.
- R6: While bit 31 of the machine high word is 1, writes to all four configuration words are ignored.
- R7: A source is issued only when dom_ie_i is 1 and the source is both pending and enabled. Otherwise it stays pending and nothing is sent.
- R8: When a source's request is loaded onto the output, its pending bit clears.
- R9: Among eligible sources, the lowest-numbered one is issued first.
- R10: While msg_valid_o is 1 and msg_ready_i is 0, the address and data hold stable, and no new source is selected.
- R11: A generate write sends one message to hart wdata[31:18], with guest index 0 and identity wdata[10:0], regardless of dom_ie_i. A waiting generate request is issued before any waiting source.
- R12: If a source's set pulse coincides with the cycle its pending bit is consumed, the source stays pending and is issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mlevel_i | input | 1 | 1 selects machine-level behaviour, 0 selects supervisor-level behaviour |
| dom_ie_i | input | 1 | Domain interrupt enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_kind_i | input | 3 | Register being written |
| reg_idx_i | input | SRCW | Source number for target writes |
| reg_wdata_i | input | 32 | Write data |
| src_set_i | input | NSRC | Per-source pending set pulses |
| src_en_i | input | NSRC | Per-source enables |
| src_pend_o | output | NSRC | Per-source pending bits |
| msg_valid_o | output | 1 | Write request valid |
| msg_ready_i | input | 1 | Write request accepted |
| msg_addr_o | output | 64 | Message byte address |
| msg_data_o | output | 32 | Message data (identity) |

## Verification
The assertions assume that the write interface holds msg_ready_i as a plain level and never withdraws acceptance in a way that matters to the block. They also assume that set pulses and enables change only between clock edges. The stimulus drives every input on the falling edge. It varies msg_ready_i only while a request is waiting, so a held request is observed over several cycles. It never writes the generate register a second time before the earlier generate request has been sent.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int HART_W  = 14;
  localparam int GUEST_W = 6;
  localparam int EIID_W  = 11;
  localparam int HART_LSB  = 18;
  localparam int GUEST_LSB = 12;

  typedef enum logic [2:0] {
    RK_M_LO = 3'd0,
    RK_M_HI = 3'd1,
    RK_S_LO = 3'd2,
    RK_S_HI = 3'd3,
    RK_GEN  = 3'd4,
    RK_TGT  = 3'd5
  } reg_kind_e;

  typedef struct packed {
    logic [HART_W-1:0]  hart;
    logic [GUEST_W-1:0] guest;
    logic [EIID_W-1:0]  eiid;
  } tgt_t;

  typedef struct packed {
    logic [4:0]  gshift;
    logic [2:0]  lshift;
    logic [2:0]  gwidth;
    logic [3:0]  lwidth;
    logic [11:0] base_hi;
  } addr_fmt_t;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int SRCW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [2:0]           kind_i,
  input  logic [SRCW-1:0]      idx_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          m_lo_o,
  output addr_fmt_t            m_fmt_o,
  output logic [31:0]          s_lo_o,
  output addr_fmt_t            s_fmt_o,
  output tgt_t [NSRC-1:0]      tgt_o
);
  logic [31:0]     m_lo_q, m_lo_d, s_lo_q, s_lo_d;
  addr_fmt_t       m_fmt_q, m_fmt_d, s_fmt_q, s_fmt_d;
  logic            lock_q, lock_d;
  tgt_t [NSRC-1:0] tgt_q, tgt_d;
  addr_fmt_t       wfmt;
  tgt_t            wtgt;

  always_comb begin
    wfmt = '{gshift: wdata_i[28:24], lshift: wdata_i[22:20],
             gwidth: wdata_i[18:16], lwidth: wdata_i[15:12],
             base_hi: wdata_i[11:0]};
    wtgt = '{hart: wdata_i[HART_LSB +: HART_W],
             guest: wdata_i[GUEST_LSB +: GUEST_W],
             eiid: wdata_i[EIID_W-1:0]};
  end

  always_comb begin
    m_lo_d  = m_lo_q;
    m_fmt_d = m_fmt_q;
    s_lo_d  = s_lo_q;
    s_fmt_d = s_fmt_q;
    lock_d  = lock_q;
    tgt_d   = tgt_q;
    case (kind_i)
      RK_M_LO: if (!lock_q) m_lo_d = wdata_i;
      RK_M_HI: if (!lock_q) begin
        m_fmt_d = wfmt;
        lock_d  = wdata_i[31];
      end
      RK_S_LO: if (!lock_q) s_lo_d = wdata_i;
      RK_S_HI: if (!lock_q) s_fmt_d = wfmt;
      RK_TGT:  if (int'(idx_i) < NSRC) tgt_d[idx_i] = wtgt;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo_q  <= '0;
      m_fmt_q <= '0;
      s_lo_q  <= '0;
      s_fmt_q <= '0;
      lock_q  <= 1'b0;
      tgt_q   <= '0;
    end else if (we_i) begin
      m_lo_q  <= m_lo_d;
      m_fmt_q <= m_fmt_d;
      s_lo_q  <= s_lo_d;
      s_fmt_q <= s_fmt_d;
      lock_q  <= lock_d;
      tgt_q   <= tgt_d;
    end
  end

  assign m_lo_o  = m_lo_q;
  assign m_fmt_o = m_fmt_q;
  assign s_lo_o  = s_lo_q;
  assign s_fmt_o = s_fmt_q;
  assign tgt_o   = tgt_q;
endmodule

// File: rtl/msi_addr_calc.sv
module msi_addr_calc
  import msi_pkg::*;
(
  input  logic [31:0]        lo_i,
  input  addr_fmt_t          fmt_i,
  input  logic [HART_W-1:0]  hart_i,
  input  logic [GUEST_W-1:0] guest_i,
  output logic [63:0]        addr_o
);
  logic [63:0] hart_w, grp, mbr, ppn;
  logic [6:0]  gsh;

  always_comb begin
    hart_w = {{(64-HART_W){1'b0}}, hart_i};
    grp    = hart_w >> fmt_i.lwidth;
    mbr    = hart_w & ((64'd1 << fmt_i.lwidth) - 64'd1);
    gsh    = {2'b00, fmt_i.gshift} + 7'd12;
    ppn    = {20'd0, fmt_i.base_hi, lo_i};
    ppn    = ppn | ((grp & ((64'd1 << fmt_i.gwidth) - 64'd1)) << gsh);
    ppn    = ppn | (mbr << fmt_i.lshift);
    ppn    = ppn | ({{(64-GUEST_W){1'b0}}, guest_i} &
                    ((64'd1 << fmt_i.lshift) - 64'd1));
    addr_o = ppn << 12;
  end
endmodule

// File: rtl/msi_src_pick.sv
module msi_src_pick #(
  parameter int NSRC = 8,
  parameter int SRCW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            ie_i,
  input  logic            take_i,
  output logic [NSRC-1:0] pend_o,
  output logic            any_o,
  output logic [SRCW-1:0] idx_o
);
  logic [NSRC-1:0] pend_q, pend_d, elig, clr;

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = pend_q[g] & en_i[g] & ie_i;
  end

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && !any_o) begin
        any_o = 1'b1;
        idx_o = SRCW'(i);
      end
    end
  end

  always_comb begin
    clr = '0;
    if (take_i) clr[idx_o] = 1'b1;
    pend_d = (pend_q & ~clr) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/msi_msg_composer.sv
module msi_msg_composer
  import msi_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int SRCW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mlevel_i,
  input  logic            dom_ie_i,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_kind_i,
  input  logic [SRCW-1:0] reg_idx_i,
  input  logic [31:0]     reg_wdata_i,
  input  logic [NSRC-1:0] src_set_i,
  input  logic [NSRC-1:0] src_en_i,
  output logic [NSRC-1:0] src_pend_o,
  output logic            msg_valid_o,
  input  logic            msg_ready_i,
  output logic [63:0]     msg_addr_o,
  output logic [31:0]     msg_data_o
);
  logic [31:0]        m_lo, s_lo, sel_lo;
  addr_fmt_t          m_fmt, s_fmt, sel_fmt;
  tgt_t [NSRC-1:0]    tgt;
  logic               src_any, src_fire, gen_take, load_en;
  logic [SRCW-1:0]    pick_idx;
  logic               gen_pend_q, gen_pend_d;
  logic [HART_W-1:0]  gen_hart_q, gen_hart_d;
  logic [EIID_W-1:0]  gen_eiid_q, gen_eiid_d;
  logic [HART_W-1:0]  c_hart;
  logic [GUEST_W-1:0] c_guest;
  logic [EIID_W-1:0]  c_eiid;
  logic [63:0]        c_addr;
  logic               valid_q, valid_d;
  logic [63:0]        addr_q;
  logic [EIID_W-1:0]  eiid_q;

  msi_cfg_regs #(.NSRC(NSRC), .SRCW(SRCW)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .kind_i(reg_kind_i),
    .idx_i(reg_idx_i), .wdata_i(reg_wdata_i),
    .m_lo_o(m_lo), .m_fmt_o(m_fmt), .s_lo_o(s_lo), .s_fmt_o(s_fmt),
    .tgt_o(tgt)
  );

  msi_src_pick #(.NSRC(NSRC), .SRCW(SRCW)) pick_i (
    .clk(clk), .rst_n(rst_n), .set_i(src_set_i), .en_i(src_en_i),
    .ie_i(dom_ie_i), .take_i(src_fire), .pend_o(src_pend_o),
    .any_o(src_any), .idx_o(pick_idx)
  );

  // selection: a waiting generate request wins over sources
  assign gen_take = !valid_q && gen_pend_q;
  assign src_fire = !valid_q && !gen_pend_q && src_any;
  assign load_en  = gen_take || src_fire;

  always_comb begin
    gen_pend_d = gen_pend_q && !gen_take;
    gen_hart_d = gen_hart_q;
    gen_eiid_d = gen_eiid_q;
    if (reg_we_i && reg_kind_i == RK_GEN) begin
      gen_pend_d = 1'b1;
      gen_hart_d = reg_wdata_i[HART_LSB +: HART_W];
      gen_eiid_d = reg_wdata_i[EIID_W-1:0];
    end
  end

  always_comb begin
    if (gen_pend_q) begin
      c_hart  = gen_hart_q;
      c_guest = '0;
      c_eiid  = gen_eiid_q;
    end else begin
      c_hart  = tgt[pick_idx].hart;
      c_guest = mlevel_i ? '0 : tgt[pick_idx].guest;
      c_eiid  = tgt[pick_idx].eiid;
    end
    sel_lo  = mlevel_i ? m_lo  : s_lo;
    sel_fmt = mlevel_i ? m_fmt : s_fmt;
  end

  msi_addr_calc calc_i (
    .lo_i(sel_lo), .fmt_i(sel_fmt), .hart_i(c_hart), .guest_i(c_guest),
    .addr_o(c_addr)
  );

  always_comb begin
    valid_d = valid_q;
    if (valid_q && msg_ready_i) valid_d = 1'b0;
    if (load_en)                valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_pend_q <= 1'b0;
      gen_hart_q <= '0;
      gen_eiid_q <= '0;
      valid_q    <= 1'b0;
      addr_q     <= '0;
      eiid_q     <= '0;
    end else begin
      gen_pend_q <= gen_pend_d;
      gen_hart_q <= gen_hart_d;
      gen_eiid_q <= gen_eiid_d;
      valid_q    <= valid_d;
      if (load_en) begin
        addr_q <= c_addr;
        eiid_q <= c_eiid;
      end
    end
  end

  assign msg_valid_o = valid_q;
  assign msg_addr_o  = addr_q;
  assign msg_data_o  = {{(32-EIID_W){1'b0}}, eiid_q};
endmodule

// File: rtl/msi_msg_composer_chk.sv
module msi_msg_composer_chk #(
  parameter int NSRC = 8,
  parameter int SRCW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dom_ie_i,
  input logic [NSRC-1:0] src_set_i,
  input logic [NSRC-1:0] src_en_i,
  input logic [NSRC-1:0] src_pend_o,
  input logic            msg_valid_o,
  input logic            msg_ready_i,
  input logic [63:0]     msg_addr_o,
  input logic [31:0]     msg_data_o,
  input logic            src_fire,
  input logic [SRCW-1:0] pick_idx
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && !msg_ready_i |=>
      msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> !src_fire);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    src_fire |-> dom_ie_i && src_pend_o[pick_idx] && src_en_i[pick_idx]);

  p_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    src_fire |->
      ((src_pend_o & src_en_i) & ((NSRC'(1) << pick_idx) - NSRC'(1))) == '0);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    src_fire && !src_set_i[pick_idx] |=> !src_pend_o[$past(pick_idx)]);

  p_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    src_fire && src_set_i[pick_idx] |=> src_pend_o[$past(pick_idx)]);

  p_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> msg_data_o[31:11] == '0);
endmodule

bind msi_msg_composer msi_msg_composer_chk #(.NSRC(NSRC), .SRCW(SRCW)) chk_i (
  .clk(clk), .rst_n(rst_n), .dom_ie_i(dom_ie_i), .src_set_i(src_set_i),
  .src_en_i(src_en_i), .src_pend_o(src_pend_o), .msg_valid_o(msg_valid_o),
  .msg_ready_i(msg_ready_i), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o),
  .src_fire(src_fire), .pick_idx(pick_idx)
);

// File: tb/msi_msg_composer_tb.sv
`timescale 1ns/100ps
module msi_msg_composer_tb_top;
  localparam int NSRC = 8;
  localparam int SRCW = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            mlevel_i, dom_ie_i, reg_we_i, msg_ready_i;
  logic [2:0]      reg_kind_i;
  logic [SRCW-1:0] reg_idx_i;
  logic [31:0]     reg_wdata_i;
  logic [NSRC-1:0] src_set_i, src_en_i, src_pend_o;
  logic            msg_valid_o;
  logic [63:0]     msg_addr_o;
  logic [31:0]     msg_data_o;

  int checks = 0;
  int errors = 0;
  logic [95:0] exp_q[$];
  logic [63:0] held_addr;

  always #2 clk = ~clk;

  msi_msg_composer #(.NSRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .mlevel_i(mlevel_i), .dom_ie_i(dom_ie_i),
    .reg_we_i(reg_we_i), .reg_kind_i(reg_kind_i), .reg_idx_i(reg_idx_i),
    .reg_wdata_i(reg_wdata_i), .src_set_i(src_set_i), .src_en_i(src_en_i),
    .src_pend_o(src_pend_o), .msg_valid_o(msg_valid_o),
    .msg_ready_i(msg_ready_i), .msg_addr_o(msg_addr_o),
    .msg_data_o(msg_data_o)
  );

  function automatic logic [63:0] exp_addr(input logic [31:0] lo,
      input logic [31:0] hi, input int hart, input int guest);
    int lw = int'((hi >> 12) & 32'hF);
    int gw = int'((hi >> 16) & 32'h7);
    int ls = int'((hi >> 20) & 32'h7);
    int gs = int'((hi >> 24) & 32'h1F);
    logic [63:0] p;
    p = {20'd0, hi[11:0], lo};
    p = p | (((64'(hart) >> lw) & ((64'd1 << gw) - 64'd1)) << (gs + 12));
    p = p | ((64'(hart) & ((64'd1 << lw) - 64'd1)) << ls);
    p = p | (64'(guest) & ((64'd1 << ls) - 64'd1));
    return p << 12;
  endfunction

  function automatic logic [31:0] tword(input int h, input int g, input int e);
    return (32'(h) << 18) | (32'(g) << 12) | 32'(e);
  endfunction

  task automatic check(input string req, input logic [95:0] act,
                       input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] a, input int e);
    exp_q.push_back({a, 32'(e)});
  endtask

  task automatic wr(input logic [2:0] k, input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_kind_i = k; reg_idx_i = SRCW'(idx); reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic pulse(input logic [NSRC-1:0] m);
    @(negedge clk);
    src_set_i = m;
    @(negedge clk);
    src_set_i = '0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((exp_q.size() != 0 || msg_valid_o) && n < 300) begin
      @(negedge clk); #1; n++;
    end
    if (n >= 300) begin
      checks++; errors++;
      $display("FAIL %s drain timeout actual=%0d expected=0 left", req,
               exp_q.size());
    end
  endtask

  // monitor: scoreboard compare at each accepted transfer
  always begin
    @(negedge clk); #1;
    if (rst_n && msg_valid_o && msg_ready_i) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected message actual=%h/%h expected=none",
                 msg_addr_o, msg_data_o);
      end else begin
        check("R3 R4 message", {msg_addr_o, msg_data_o}, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] mlo, mhi, slo, shi;
    mlo = 32'h0002_0000;
    mhi = (32'd3 << 24) | (32'd1 << 20) | (32'd2 << 16) | (32'd2 << 12) | 32'h005;
    slo = 32'h1000_0000;
    shi = (32'd4 << 24) | (32'd3 << 20) | (32'd3 << 16) | (32'd3 << 12) | 32'h0A0;
    rst_n = 1'b0; mlevel_i = 1'b1; dom_ie_i = 1'b0; reg_we_i = 1'b0;
    reg_kind_i = '0; reg_idx_i = '0; reg_wdata_i = '0; src_set_i = '0;
    src_en_i = '0; msg_ready_i = 1'b1;
    settle(3);
    @(negedge clk); rst_n = 1'b1;
    settle(1);
    check("R1 valid", 96'(msg_valid_o), 96'(0));
    check("R1 pending", 96'(src_pend_o), 96'(0));

    // configuration; high word carries junk in masked bits (R2)
    wr(3'd0, 0, mlo);
    wr(3'd1, 0, mhi | 32'h6088_0000);
    wr(3'd5, 0, tword(2, 0, 'h100));
    wr(3'd5, 1, tword(6, 2, 'h11));
    wr(3'd5, 2, tword(13, 5, 'h2A));
    wr(3'd5, 3, tword('h3FFF, 'h3F, 'h7FF));
    wr(3'd5, 4, tword(1, 1, 5));
    wr(3'd6, 2, 32'hFFFF_FFFF);  // ignored code (R2)
    dom_ie_i = 1'b1; src_en_i = '1;

    // R3 R5: machine level, guest forced to 0
    push(exp_addr(mlo, mhi, 13, 0), 'h2A);
    pulse(8'b0000_0100);
    drain("R3");
    check("R8 pending cleared", 96'(src_pend_o), 96'(0));

    // R9 R10: ordering and hold under back-pressure
    msg_ready_i = 1'b0;
    push(exp_addr(mlo, mhi, 6, 0), 'h11);
    push(exp_addr(mlo, mhi, 'h3FFF, 0), 'h7FF);
    pulse(8'b0000_1010);
    settle(2);
    check("R9 first valid", 96'(msg_valid_o), 96'(1));
    check("R8 R9 pending left", 96'(src_pend_o), 96'(8'b0000_1000));
    held_addr = msg_addr_o;
    settle(3);
    check("R10 held addr", {msg_addr_o, 31'd0, msg_valid_o}, {held_addr, 32'd1});
    check("R10 no new pick", 96'(src_pend_o), 96'(8'b0000_1000));
    msg_ready_i = 1'b1;
    drain("R9");

    // R7: domain enable off, then source enable off
    dom_ie_i = 1'b0;
    pulse(8'b0001_0000);
    settle(6);
    check("R7 ie off no msg", 96'(msg_valid_o), 96'(0));
    check("R7 ie off still pending", 96'(src_pend_o), 96'(8'b0001_0000));
    src_en_i = 8'b1110_1111; dom_ie_i = 1'b1;
    settle(6);
    check("R7 en off no msg", 96'(msg_valid_o), 96'(0));
    push(exp_addr(mlo, mhi, 1, 0), 5);
    src_en_i = '1;
    drain("R7");
    check("R7 R8 drained", 96'(src_pend_o), 96'(0));

    // R11: generate ignores domain enable and guest field
    dom_ie_i = 1'b0;
    push(exp_addr(mlo, mhi, 9, 0), 'h77);
    wr(3'd4, 0, (32'd9 << 18) | (32'h3F << 12) | 32'h77);
    drain("R11");
    dom_ie_i = 1'b1;

    // R11: generate wins over a waiting source
    msg_ready_i = 1'b0;
    push(exp_addr(mlo, mhi, 2, 0), 'h100);
    push(exp_addr(mlo, mhi, 'h21, 0), 'h3);
    push(exp_addr(mlo, mhi, 6, 0), 'h11);
    pulse(8'b0000_0001);
    settle(2);
    pulse(8'b0000_0010);
    wr(3'd4, 0, (32'h21 << 18) | 32'h3);
    settle(2);
    msg_ready_i = 1'b1;
    drain("R11 order");

    // R5: supervisor level uses supervisor pair and guest index
    mlevel_i = 1'b0;
    wr(3'd2, 0, slo);
    wr(3'd3, 0, shi);
    push(exp_addr(slo, shi, 6, 2), 'h11);
    push(exp_addr(slo, shi, 'h3FFF, 'h3F), 'h7FF);
    pulse(8'b0000_1010);
    drain("R5");
    mlevel_i = 1'b1;

    // R12: set pulse coinciding with consumption keeps the source pending
    push(exp_addr(mlo, mhi, 1, 0), 5);
    push(exp_addr(mlo, mhi, 1, 0), 5);
    @(negedge clk); src_set_i = 8'b0001_0000;
    @(negedge clk);
    @(negedge clk); src_set_i = '0;
    #1;
    check("R12 still pending", {94'd0, src_pend_o[4], msg_valid_o}, 96'(3));
    drain("R12");
    check("R12 drained", 96'(src_pend_o), 96'(0));

    // R6: lock freezes all four configuration words
    wr(3'd1, 0, mhi | 32'h8000_0000);
    wr(3'd0, 0, 32'hFFFF_0000);
    wr(3'd1, 0, 32'h0);
    wr(3'd2, 0, 32'h5555_0000);
    wr(3'd3, 0, 32'h0);
    push(exp_addr(mlo, mhi, 13, 0), 'h2A);
    pulse(8'b0000_0100);
    drain("R6 machine");
    mlevel_i = 1'b0;
    push(exp_addr(slo, shi, 6, 2), 'h11);
    pulse(8'b0000_0010);
    drain("R6 supervisor");

    settle(2);
    check("R10 queue empty", 96'(exp_q.size()), 96'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule